// File: doc/BRIEF.md
# PWM Tick Prescaler and Channel Clock Selector

This block derives the per-channel clock-enable strobes for a bank of PWM channels from a single bus clock. It produces no derived clocks. Each output is a one-cycle pulse in the bus clock domain. Downstream channel counters advance only in the cycles where their strobe is high.

There are two cascaded divider stages for each of two groups, A and B. The first stage divides the bus clock by a power of two, 2^N, where N comes from a 3-bit field. The second stage counts first-stage ticks and divides them further by 2×M. M is an 8-bit value, and the value 0 stands for 256.

Each channel belongs to one group, fixed by its index. A select bit per channel picks either the base tick or the scaled tick of that group. Configuration is written through a plain write strobe with a 2-bit register address. No data stream passes through the block, so every pin is a plain control or status pin and there is no back-pressure.

Top module: `pwmclk_gen`

## Requirements
- R1: After reset, all fields are zero. Both base ticks are high on every cycle, both scaled ticks fire once every 512 cycles, and every channel follows its base tick.
- R2: Address 0 holds the group-A exponent NA in wr_data bits [2:0]. After a write there, tick_base_a is high in cycle 2^NA−1 counted from the first cycle after the write, and then every 2^NA cycles.
- R3: Address 0 holds the group-B exponent NB in wr_data bits [6:4]. tick_base_b follows the same timing with 2^NB.
- R4: Address 1 holds MA and address 2 holds MB. A scaled tick is high on every (2×M)-th base tick of its group and only in a cycle where that base tick is high. The first one falls on base tick number 2×M after its counter was cleared.
- R5: A scale value of 0 acts as 256, giving a scaled period of 512 base ticks.
- R6: Channels with (index/2) even (0, 1, 4, 5) use group A. Channels with (index/2) odd (2, 3, 6, 7) use group B.
- R7: Address 3 holds the select mask, with bit i belonging to channel i. A 0 drives chan_tick[i] from the group's base tick and a 1 drives it from the group's scaled tick.
- R8: Every tick whose period exceeds one cycle is exactly one cycle wide.
- R9: A write to address 0 restarts all four divider counters. A write to address 1 or 2 restarts only that group's scaled counter, so the new ratio applies from the following cycle.
- R10: A write to address 3 changes the channel routing from the next cycle and does not disturb the phase of any divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 exponents, 1 scale A, 2 scale B, 3 select mask |
| wr_data | input | 8 | Write data |
| tick_base_a | output | 1 | Group-A base tick |
| tick_base_b | output | 1 | Group-B base tick |
| tick_scl_a | output | 1 | Group-A scaled tick |
| tick_scl_b | output | 1 | Group-B scaled tick |
| chan_tick | output | 8 | Per-channel selected tick |

## Verification
The first pattern is the reset configuration. It shows that a zero scale acts as 256 and that a zero exponent gives a strobe on every cycle.

The directed patterns cover the following:
- The smallest scale, which shows where the scaled tick lands within the base tick train.
- Mixed exponents with alternating and split select masks, which show the group each channel belongs to and the base-or-scaled choice.
- A divide-by-128 with a scale of 250, which checks the longest cascaded count.
- A scale write in the middle of a run, which shows that only the matching scaled counter restarts.
- A select write in the middle of a window, which shows that routing changes without any shift in phase.

Seeded random configurations then compare every output on every cycle against periods computed from the exponent and the scale.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
  typedef enum logic [1:0] {
    ADDR_EXP   = 2'd0,
    ADDR_SCL_A = 2'd1,
    ADDR_SCL_B = 2'd2,
    ADDR_SEL   = 2'd3
  } reg_addr_e;

  localparam int N_GRP = 2;
endpackage

// File: rtl/pwmclk_base_div.sv
module pwmclk_base_div #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] exp_sel,
  output logic             tick
);
  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // terminal count is 2^exp - 1
  assign lim  = ~({CNT_W{1'b1}} << exp_sel);
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmclk_scale_div.sv
module pwmclk_scale_div #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               in_tick,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  localparam int CNT_W = SCALE_W + 1;

  logic [SCALE_W-1:0] scale_m1;
  logic [CNT_W-1:0]   lim;
  logic [CNT_W-1:0]   cnt_q;

  // 2*M - 1 == {M-1, 1}; M = 0 wraps to all ones, i.e. acts as 2^SCALE_W
  assign scale_m1 = scale - SCALE_W'(1);
  assign lim      = {scale_m1, 1'b1};
  assign tick     = in_tick && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (in_tick)  cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmclk_chan_mux.sv
module pwmclk_chan_mux #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] sel,
  input  logic [1:0]     base_tick,
  input  logic [1:0]     scl_tick,
  output logic [NCH-1:0] chan_tick
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP = (i / 2) % 2;
    assign chan_tick[i] = sel[i] ? scl_tick[GRP] : base_tick[GRP];
  end
endmodule

// File: rtl/pwmclk_gen.sv
module pwmclk_gen
  import pwmclk_pkg::*;
#(
  parameter int PRE_W   = 3,
  parameter int SCALE_W = 8,
  parameter int NCH     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [SCALE_W-1:0] wr_data,
  output logic               tick_base_a,
  output logic               tick_base_b,
  output logic               tick_scl_a,
  output logic               tick_scl_b,
  output logic [NCH-1:0]     chan_tick
);
  localparam int B_LSB = SCALE_W / 2;

  logic [PRE_W-1:0]   pre_q   [N_GRP];
  logic [SCALE_W-1:0] scale_q [N_GRP];
  logic [NCH-1:0]     sel_q;
  logic [N_GRP-1:0]   base_tick, scl_tick, clr_scl;
  logic               clr_base;

  assign clr_base   = wr_en && (wr_addr == ADDR_EXP);
  assign clr_scl[0] = clr_base || (wr_en && (wr_addr == ADDR_SCL_A));
  assign clr_scl[1] = clr_base || (wr_en && (wr_addr == ADDR_SCL_B));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < N_GRP; g++) begin
        pre_q[g]   <= '0;
        scale_q[g] <= '0;
      end
      sel_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_EXP: begin
          pre_q[0] <= wr_data[PRE_W-1:0];
          pre_q[1] <= wr_data[B_LSB +: PRE_W];
        end
        ADDR_SCL_A: scale_q[0] <= wr_data;
        ADDR_SCL_B: scale_q[1] <= wr_data;
        default:    sel_q      <= wr_data[NCH-1:0];
      endcase
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pwmclk_base_div #(.PRE_W(PRE_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_base),
      .exp_sel (pre_q[g]),
      .tick    (base_tick[g])
    );
    pwmclk_scale_div #(.SCALE_W(SCALE_W)) u_scl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_scl[g]),
      .in_tick (base_tick[g]),
      .scale   (scale_q[g]),
      .tick    (scl_tick[g])
    );
  end

  pwmclk_chan_mux #(.NCH(NCH)) u_mux (
    .sel       (sel_q),
    .base_tick (base_tick),
    .scl_tick  (scl_tick),
    .chan_tick (chan_tick)
  );

  assign tick_base_a = base_tick[0];
  assign tick_base_b = base_tick[1];
  assign tick_scl_a  = scl_tick[0];
  assign tick_scl_b  = scl_tick[1];
endmodule

// File: rtl/pwmclk_gen_chk.sv
module pwmclk_gen_chk #(
  parameter int PRE_W = 3,
  parameter int NCH   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [PRE_W-1:0] exp_a,
  input logic [PRE_W-1:0] exp_b,
  input logic             tick_base_a,
  input logic             tick_base_b,
  input logic             tick_scl_a,
  input logic             tick_scl_b,
  input logic [NCH-1:0]   chan_tick
);
  // R2: zero exponent gives a strobe every cycle
  a_r2_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_a == '0) |-> tick_base_a);

  // R8: divided base tick is one cycle wide
  a_r8_base_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_base_b && exp_b != '0 && !wr_en) |=> !tick_base_b);

  // R8: scaled tick never lasts two cycles
  a_r8_scl_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_scl_a |=> !tick_scl_a);

  // R4: scaled tick only coincides with its base tick
  a_r4_scl_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_scl_a |-> tick_base_a) and (tick_scl_b |-> tick_base_b));

  // R6: group-A and group-B channels follow only their own group
  a_r6_grp_a: assert property (@(posedge clk) disable iff (!rst_n)
    chan_tick[0] |-> (tick_base_a || tick_scl_a));
  a_r6_grp_b: assert property (@(posedge clk) disable iff (!rst_n)
    chan_tick[2] |-> (tick_base_b || tick_scl_b));

  // R9: an exponent write restarts the scaled counters
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (!tick_scl_a && !tick_scl_b));
endmodule

bind pwmclk_gen pwmclk_gen_chk #(.PRE_W(PRE_W), .NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .exp_a       (pre_q[0]),
  .exp_b       (pre_q[1]),
  .tick_base_a (tick_base_a),
  .tick_base_b (tick_base_b),
  .tick_scl_a  (tick_scl_a),
  .tick_scl_b  (tick_scl_b),
  .chan_tick   (chan_tick)
);

// File: tb/pwmclk_gen_test.sv
`timescale 1ns/1ps
module pwmclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_base_a, tick_base_b, tick_scl_a, tick_scl_b;
  logic [7:0] chan_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwmclk_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_base_a(tick_base_a), .tick_base_b(tick_base_b),
    .tick_scl_a(tick_scl_a), .tick_scl_b(tick_scl_b), .chan_tick(chan_tick)
  );

  function automatic bit due(longint t, longint p);
    return ((t + 1) % p) == 0;
  endfunction

  function automatic longint scl_period(int n, int m);
    return (longint'(1) << n) * 2 * ((m == 0) ? 256 : m);
  endfunction

  task automatic report(bit bad, string tag, string msg);
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // caller is at a negedge; returns at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(int na, int nb, int ma, int mb, logic [7:0] sel);
    wr(2'd1, 8'(ma));
    wr(2'd2, 8'(mb));
    wr(2'd3, sel);
    wr(2'd0, {1'b0, 3'(nb), 1'b0, 3'(na)});
  endtask

  task automatic run_window(string scen, int w, int na, int nb, int ma, int mb,
                            logic [7:0] sel0, int off_sa, int off_b,
                            int mid, logic [7:0] sel1);
    longint pa  = longint'(1) << na;
    longint pb  = longint'(1) << nb;
    longint psa = scl_period(na, ma);
    longint psb = scl_period(nb, mb);
    bit b_ba = 0, b_bb = 0, b_sa = 0, b_sb = 0, b_ch = 0;
    string m_ba = "", m_bb = "", m_sa = "", m_sb = "", m_ch = "";
    for (int t = 0; t < w; t++) begin
      logic [7:0] sel_now = (mid >= 0 && t > mid) ? sel1 : sel0;
      logic e_ba = due(t + off_b, pa);
      logic e_bb = due(t + off_b, pb);
      logic e_sa = due(t + off_sa, psa);
      logic e_sb = due(t + off_b, psb);
      logic [7:0] e_ch;
      if (mid >= 0 && t == mid + 1) wr_en = 1'b0;
      for (int i = 0; i < 8; i++) begin
        int g = (i / 2) % 2;
        e_ch[i] = sel_now[i] ? ((g == 0) ? e_sa : e_sb) : ((g == 0) ? e_ba : e_bb);
      end
      #1;
      if (tick_base_a !== e_ba && !b_ba) begin b_ba = 1; m_ba = $sformatf("t=%0d got %b exp %b", t, tick_base_a, e_ba); end
      if (tick_base_b !== e_bb && !b_bb) begin b_bb = 1; m_bb = $sformatf("t=%0d got %b exp %b", t, tick_base_b, e_bb); end
      if (tick_scl_a  !== e_sa && !b_sa) begin b_sa = 1; m_sa = $sformatf("t=%0d got %b exp %b", t, tick_scl_a, e_sa); end
      if (tick_scl_b  !== e_sb && !b_sb) begin b_sb = 1; m_sb = $sformatf("t=%0d got %b exp %b", t, tick_scl_b, e_sb); end
      if (chan_tick   !== e_ch && !b_ch) begin b_ch = 1; m_ch = $sformatf("t=%0d got %h exp %h", t, chan_tick, e_ch); end
      if (mid >= 0 && t == mid) begin
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = sel1;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    report(b_ba, {scen, " R2 R8 base A"}, m_ba);
    report(b_bb, {scen, " R3 R8 base B"}, m_bb);
    report(b_sa, {scen, " R4 R5 scaled A"}, m_sa);
    report(b_sb, {scen, " R4 R5 scaled B"}, m_sb);
    report(b_ch, {scen, " R6 R7 channels"}, m_ch);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    run_window("R1", 1100, 0, 0, 0, 0, 8'h00, 0, 0, -1, 8'h00);

    // smallest scale, alternating select
    cfg(0, 0, 1, 1, 8'h55);
    run_window("min-scale", 40, 0, 0, 1, 1, 8'h55, 0, 0, -1, 8'h00);

    // mixed exponents, R10 select write mid-window
    cfg(7, 3, 3, 0, 8'hF0);
    run_window("R10", 5000, 7, 3, 3, 0, 8'hF0, 0, 0, 2100, 8'h0F);

    // long cascade: B/128 then /500, A/64 then /512
    cfg(6, 7, 0, 250, 8'hCC);
    run_window("long", 64010, 6, 7, 0, 250, 8'hCC, 0, 0, -1, 8'h00);

    // R9: scale-A write mid-run restarts only scaled A
    cfg(0, 0, 2, 2, 8'hFF);
    run_window("R9-pre", 3, 0, 0, 2, 2, 8'hFF, 0, 0, -1, 8'h00);
    wr(2'd1, 8'd3);
    run_window("R9", 40, 0, 0, 3, 2, 8'hFF, 0, 4, -1, 8'h00);

    // random configurations
    for (int k = 0; k < 10; k++) begin
      int na = $urandom_range(0, 7);
      int nb = $urandom_range(0, 7);
      int ma = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 4);
      int mb = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 4);
      logic [7:0] sel = 8'($urandom);
      cfg(na, nb, ma, mb, sel);
      run_window($sformatf("rand%0d", k), 800, na, nb, ma, mb, sel, 0, 0, -1, 8'h00);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule